// File: doc/BRIEF.md
# Multiple-Register Block Transfer Sequencer

This block moves a group of registers between a register file and a word-addressed memory in response to one command. A 16-bit selection vector picks which registers take part, one bit per register. A base address, a direction bit (load or store), an index-before bit and an upward/downward bit come with it. A writeback bit is also supplied. Once started, the block makes one memory access for each selected register. Registers are visited from the lowest number to the highest, and each access is one word (4 bytes) above the previous one. The lowest-numbered selected register therefore always lands at the lowest address of the block.

The four address modes are formed from the two mode bits. Upward without pre-index starts at the base. Upward with pre-index starts one word above it. Downward with pre-index starts 4N bytes below the base. Downward without pre-index starts 4N-4 below it. Because of this, a full-descending stack push uses the downward pre-indexed form and its matching pop uses the upward post-indexed form. When the transfer finishes, the block presents the adjusted base, which is the base plus or minus 4N. It raises a single writeback strobe if writeback was requested. The command cannot be interrupted: a new start is ignored until the transfer has finished.

Top module: `blkx_seq`

## Requirements
- R1: After synchronous reset, and whenever the block is idle, busy, done, mem_req, rf_we and base_we are all 0.
- R2: A start sampled while idle is accepted. With mem_rdy held at 1 and N selected registers, busy stays high for exactly N+2 cycles. A start sampled while busy is ignored.
- R3: The block issues one access per set bit of the selection vector, in ascending register index. Each accepted access is followed by one whose address is 4 higher.
- R4: The first access address is base (up=1, pre=0), base+4 (up=1, pre=1), base-4N+4 (up=0, pre=0), or base-4N (up=0, pre=1).
- R5: new_base equals base+4N when up=1 and base-4N when up=0, and it is valid while done is high. base_we is high in the done cycle exactly when writeback=1, and at no other time.
- R6: On a load, mem_we is 0. In every cycle where mem_rdy is 1 during an access, rf_we is 1, with rf_widx set to the register index and rf_wdata equal to mem_rdata.
- R7: On a store, mem_we is 1, rf_ridx gives the register index, and mem_wdata carries rf_rdata.
- R8: While mem_rdy is 0, the pending access is held with unchanged address and register index.
- R9: An all-zero selection vector makes no memory access. It raises done in the second cycle after start, and busy is high for 2 cycles.
- R10: done is a one-cycle pulse and is followed by the idle state. new_base holds its value until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Command strobe, taken only when idle |
| reg_sel | input | 16 | One bit per register to transfer |
| base_addr | input | 32 | Base byte address |
| is_load | input | 1 | 1 = memory to registers, 0 = registers to memory |
| pre_idx | input | 1 | Step the address before the first access |
| up | input | 1 | 1 = addresses above base, 0 = below |
| wb_en | input | 1 | Request base writeback at the end |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle end-of-transfer pulse |
| new_base | output | 32 | Adjusted base value |
| base_we | output | 1 | Base writeback strobe |
| mem_req | output | 1 | Memory access valid |
| mem_addr | output | 32 | Memory byte address |
| mem_we | output | 1 | Memory write enable |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data |
| mem_rdy | input | 1 | Access completes this cycle |
| rf_ridx | output | 4 | Register file read index |
| rf_rdata | input | 32 | Register file read data |
| rf_we | output | 1 | Register file write enable |
| rf_widx | output | 4 | Register file write index |
| rf_wdata | output | 32 | Register file write data |

## Verification
After start is sampled, busy rises at the next edge. The first access is presented one edge after that, and each access then holds until the edge where mem_rdy is sampled high. done follows the last completed access by one edge, so with a single-cycle memory it appears N+1 edges after the start edge. The bench models this edge count behaviourally with a queue of pending registers. It advances the model on the same edges and compares every output at the falling edge, after inputs have settled. Inputs change just after each rising edge. Transfer lengths measured by the bench are checked against N+2 and against 2 for an empty selection.

// File: rtl/blkx_pkg.sv
package blkx_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SETUP = 2'd1,
    ST_XFER  = 2'd2,
    ST_FIN   = 2'd3
  } blkx_state_e;

  // word size in bytes expressed as a shift
  localparam int WORD_SHIFT = 2;
endpackage

// File: rtl/blkx_popcnt.sv
module blkx_popcnt #(
  parameter int W  = 16,
  parameter int CW = $clog2(W + 1)
) (
  input  logic [W-1:0]  vec,
  output logic [CW-1:0] cnt
);
  logic [CW-1:0] part [W+1];

  assign part[0] = '0;
  for (genvar g = 0; g < W; g++) begin : g_sum
    assign part[g+1] = part[g] + CW'(vec[g]);
  end
  assign cnt = part[W];
endmodule

// File: rtl/blkx_lowbit.sv
module blkx_lowbit #(
  parameter int W  = 16,
  parameter int IW = $clog2(W)
) (
  input  logic [W-1:0]  vec,
  output logic [W-1:0]  onehot,
  output logic [IW-1:0] idx
);
  assign onehot = vec & (~vec + W'(1));

  always_comb begin
    idx = '0;
    for (int i = W - 1; i >= 0; i--) begin
      if (vec[i]) idx = IW'(i);
    end
  end
endmodule

// File: rtl/blkx_addr_gen.sv
module blkx_addr_gen
  import blkx_pkg::*;
#(
  parameter int AW = 32,
  parameter int CW = 5
) (
  input  logic [AW-1:0] base,
  input  logic [CW-1:0] cnt,
  input  logic          pre,
  input  logic          up,
  output logic [AW-1:0] first_addr,
  output logic [AW-1:0] final_base
);
  localparam logic [AW-1:0] STEP = AW'(1) << WORD_SHIFT;

  logic [AW-1:0] span;
  logic [AW-1:0] low_end;

  assign span       = AW'(cnt) << WORD_SHIFT;
  assign low_end    = base - span;
  assign final_base = up ? (base + span) : low_end;

  always_comb begin
    unique case ({up, pre})
      2'b10:   first_addr = base;
      2'b11:   first_addr = base + STEP;
      2'b01:   first_addr = low_end;
      default: first_addr = low_end + STEP;
    endcase
  end
endmodule

// File: rtl/blkx_seq.sv
module blkx_seq
  import blkx_pkg::*;
#(
  parameter int NREG = 16,
  parameter int AW   = 32,
  parameter int DW   = 32,
  parameter int IW   = $clog2(NREG),
  parameter int CW   = $clog2(NREG + 1)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start,
  input  logic [NREG-1:0] reg_sel,
  input  logic [AW-1:0]   base_addr,
  input  logic            is_load,
  input  logic            pre_idx,
  input  logic            up,
  input  logic            wb_en,
  output logic            busy,
  output logic            done,
  output logic [AW-1:0]   new_base,
  output logic            base_we,
  output logic            mem_req,
  output logic [AW-1:0]   mem_addr,
  output logic            mem_we,
  output logic [DW-1:0]   mem_wdata,
  input  logic [DW-1:0]   mem_rdata,
  input  logic            mem_rdy,
  output logic [IW-1:0]   rf_ridx,
  input  logic [DW-1:0]   rf_rdata,
  output logic            rf_we,
  output logic [IW-1:0]   rf_widx,
  output logic [DW-1:0]   rf_wdata
);
  localparam logic [AW-1:0] STEP = AW'(1) << WORD_SHIFT;

  blkx_state_e     st_q;
  logic [NREG-1:0] sel_q;
  logic [NREG-1:0] pend_q;
  logic [AW-1:0]   base_q;
  logic [AW-1:0]   addr_q;
  logic [AW-1:0]   nbase_q;
  logic            load_q, pre_q, up_q, wb_q;

  logic [CW-1:0]   cnt;
  logic [AW-1:0]   first_addr;
  logic [AW-1:0]   final_base;
  logic [NREG-1:0] cur_oh;
  logic [IW-1:0]   cur_idx;
  logic [NREG-1:0] pend_nx;
  logic            in_xfer;

  blkx_popcnt #(.W(NREG), .CW(CW)) u_cnt (
    .vec (sel_q),
    .cnt (cnt)
  );

  blkx_addr_gen #(.AW(AW), .CW(CW)) u_addr (
    .base       (base_q),
    .cnt        (cnt),
    .pre        (pre_q),
    .up         (up_q),
    .first_addr (first_addr),
    .final_base (final_base)
  );

  blkx_lowbit #(.W(NREG), .IW(IW)) u_low (
    .vec    (pend_q),
    .onehot (cur_oh),
    .idx    (cur_idx)
  );

  assign pend_nx = pend_q & ~cur_oh;
  assign in_xfer = (st_q == ST_XFER);

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q    <= ST_IDLE;
      sel_q   <= '0;
      pend_q  <= '0;
      base_q  <= '0;
      addr_q  <= '0;
      nbase_q <= '0;
      load_q  <= 1'b0;
      pre_q   <= 1'b0;
      up_q    <= 1'b0;
      wb_q    <= 1'b0;
    end else begin
      unique case (st_q)
        ST_IDLE: begin
          if (start) begin
            sel_q  <= reg_sel;
            base_q <= base_addr;
            load_q <= is_load;
            pre_q  <= pre_idx;
            up_q   <= up;
            wb_q   <= wb_en;
            st_q   <= ST_SETUP;
          end
        end
        ST_SETUP: begin
          pend_q  <= sel_q;
          addr_q  <= first_addr;
          nbase_q <= final_base;
          st_q    <= (sel_q == '0) ? ST_FIN : ST_XFER;
        end
        ST_XFER: begin
          if (mem_rdy) begin
            pend_q <= pend_nx;
            addr_q <= addr_q + STEP;
            if (pend_nx == '0) st_q <= ST_FIN;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign busy      = (st_q != ST_IDLE);
  assign done      = (st_q == ST_FIN);
  assign base_we   = done & wb_q;
  assign new_base  = nbase_q;
  assign mem_req   = in_xfer;
  assign mem_addr  = addr_q;
  assign mem_we    = in_xfer & ~load_q;
  assign mem_wdata = rf_rdata;
  assign rf_ridx   = cur_idx;
  assign rf_we     = in_xfer & load_q & mem_rdy;
  assign rf_widx   = cur_idx;
  assign rf_wdata  = mem_rdata;
endmodule

// File: rtl/blkx_seq_chk.sv
module blkx_seq_chk #(
  parameter int AW = 32,
  parameter int IW = 4
) (
  input logic          clk,
  input logic          rst,
  input logic          start,
  input logic          busy,
  input logic          done,
  input logic          base_we,
  input logic          mem_req,
  input logic          mem_we,
  input logic          mem_rdy,
  input logic [AW-1:0] mem_addr,
  input logic [IW-1:0] rf_ridx,
  input logic          rf_we
);
  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (!mem_req && !rf_we && !done && !base_we));

  p_start_taken_r2: assert property (@(posedge clk) disable iff (rst)
    (start && !busy) |=> busy);

  p_addr_step_r3: assert property (@(posedge clk) disable iff (rst)
    (mem_req && mem_rdy) |=> (!mem_req || mem_addr == $past(mem_addr) + AW'(4)));

  p_reg_ascend_r3: assert property (@(posedge clk) disable iff (rst)
    (mem_req && mem_rdy) |=> (!mem_req || rf_ridx > $past(rf_ridx)));

  p_wb_in_done_r5: assert property (@(posedge clk) disable iff (rst)
    base_we |-> done);

  p_load_write_r6: assert property (@(posedge clk) disable iff (rst)
    rf_we |-> (mem_req && mem_rdy && !mem_we));

  p_hold_wait_r8: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_rdy) |=> (mem_req && $stable(mem_addr) && $stable(rf_ridx) && $stable(mem_we)));

  p_done_pulse_r10: assert property (@(posedge clk) disable iff (rst)
    done |=> (!done && !busy));
endmodule

bind blkx_seq blkx_seq_chk #(.AW(AW), .IW(IW)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .start    (start),
  .busy     (busy),
  .done     (done),
  .base_we  (base_we),
  .mem_req  (mem_req),
  .mem_we   (mem_we),
  .mem_rdy  (mem_rdy),
  .mem_addr (mem_addr),
  .rf_ridx  (rf_ridx),
  .rf_we    (rf_we)
);

// File: tb/blkx_seq_bench.sv
`timescale 1ns/1ps
module blkx_seq_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [15:0] reg_sel = '0;
  logic [31:0] base_addr = '0;
  logic        is_load = 1'b0, pre_idx = 1'b0, up = 1'b0, wb_en = 1'b0;
  logic        busy, done, base_we, mem_req, mem_we, rf_we;
  logic [31:0] new_base, mem_addr, mem_wdata, mem_rdata, rf_rdata, rf_wdata;
  logic        mem_rdy = 1'b1;
  logic [3:0]  rf_ridx, rf_widx;

  logic [31:0] mem [64];
  logic [31:0] rf  [16];

  int vectors = 0;
  int misses  = 0;
  int cyc     = 0;
  int rdy_mode = 0;
  logic [7:0] lfsr = 8'h5A;

  always #2.5 clk = ~clk;

  blkx_seq u_blkx_seq (
    .clk(clk), .rst(rst), .start(start), .reg_sel(reg_sel), .base_addr(base_addr),
    .is_load(is_load), .pre_idx(pre_idx), .up(up), .wb_en(wb_en),
    .busy(busy), .done(done), .new_base(new_base), .base_we(base_we),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_we(mem_we), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .mem_rdy(mem_rdy),
    .rf_ridx(rf_ridx), .rf_rdata(rf_rdata), .rf_we(rf_we), .rf_widx(rf_widx), .rf_wdata(rf_wdata)
  );

  assign mem_rdata = mem[mem_addr[7:2]];
  assign rf_rdata  = rf[rf_ridx];

  always @(posedge clk) begin
    if (mem_req && mem_we && mem_rdy) mem[mem_addr[7:2]] <= mem_wdata;
    if (rf_we) rf[rf_widx] <= rf_wdata;
  end

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (!ok) begin
      misses++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // behavioural reference: 0 idle, 1 setup, 2 accessing, 3 finishing
  int          m_st = 0;
  int          m_q[$];
  logic [31:0] m_addr, m_final;
  bit          m_load, m_wb;

  always @(posedge clk) begin
    if (rst) m_st = 0;
    else begin
      case (m_st)
        0: if (start) begin
          int n;
          m_q.delete();
          for (int i = 0; i < 16; i++) if (reg_sel[i]) m_q.push_back(i);
          n = m_q.size();
          if (up) m_addr = pre_idx ? base_addr + 4 : base_addr;
          else    m_addr = pre_idx ? base_addr - 4*n : base_addr - 4*n + 4;
          m_final = up ? base_addr + 4*n : base_addr - 4*n;
          m_load = is_load;
          m_wb   = wb_en;
          m_st   = 1;
        end
        1: m_st = (m_q.size() == 0) ? 3 : 2;
        2: if (mem_rdy) begin
          void'(m_q.pop_front());
          m_addr = m_addr + 4;
          if (m_q.size() == 0) m_st = 3;
        end
        default: m_st = 0;
      endcase
    end
  end

  always @(negedge clk) begin
    if (!rst) begin
      check(busy == (m_st != 0), "R2 busy", 32'(busy), 32'(m_st != 0));
      check(done == (m_st == 3), "R10 done", 32'(done), 32'(m_st == 3));
      check(mem_req == (m_st == 2), "R3 mem_req", 32'(mem_req), 32'(m_st == 2));
      if (m_st == 2) begin
        check(mem_addr == m_addr, "R4 address", mem_addr, m_addr);
        check(rf_ridx == 4'(m_q[0]), "R3 register order", 32'(rf_ridx), 32'(m_q[0]));
        if (m_load) begin
          check(mem_we == 1'b0, "R6 mem_we on load", 32'(mem_we), 0);
          check(rf_we == mem_rdy, "R6 rf_we", 32'(rf_we), 32'(mem_rdy));
          if (mem_rdy) begin
            check(rf_widx == 4'(m_q[0]), "R6 rf_widx", 32'(rf_widx), 32'(m_q[0]));
            check(rf_wdata == mem[m_addr[7:2]], "R6 rf_wdata", rf_wdata, mem[m_addr[7:2]]);
          end
        end else begin
          check(mem_we == 1'b1, "R7 mem_we on store", 32'(mem_we), 1);
          check(mem_wdata == rf[m_q[0]], "R7 mem_wdata", mem_wdata, rf[m_q[0]]);
          check(rf_we == 1'b0, "R7 no rf write", 32'(rf_we), 0);
        end
      end else begin
        check(rf_we == 1'b0, "R1 rf_we quiet", 32'(rf_we), 0);
      end
      if (m_st == 3) begin
        check(new_base == m_final, "R5 new_base", new_base, m_final);
        check(base_we == m_wb, "R5 base_we", 32'(base_we), 32'(m_wb));
      end else begin
        check(base_we == 1'b0, "R5 base_we outside done", 32'(base_we), 0);
      end
    end
  end

  task automatic tick();
    @(posedge clk);
    #1;
    lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    mem_rdy = (rdy_mode == 0) ? 1'b1 : lfsr[0];
  endtask

  // returns cycles busy and base seen at done
  task automatic run(input logic [15:0] sel, input logic [31:0] base, input bit ld,
                     input bit p, input bit u, input bit w, input bit stray,
                     output int nbusy, output logic [31:0] got_base);
    reg_sel = sel; base_addr = base; is_load = ld; pre_idx = p; up = u; wb_en = w;
    start = 1'b1;
    tick();
    start = 1'b0;
    nbusy = 0;
    got_base = 'x;
    do begin
      if (stray && nbusy == 0) begin
        start = 1'b1; reg_sel = 16'hFFFF; base_addr = 32'h0000_0F00;
      end
      tick();
      start = 1'b0;
      nbusy++;
      if (done) got_base = new_base;
    end while (busy && nbusy < 2000);
    tick();
  endtask

  initial begin
    int nb;
    logic [31:0] gb;
    for (int i = 0; i < 64; i++) mem[i] = 32'hA000_0000 | 32'(i);
    for (int i = 0; i < 16; i++) rf[i] = 32'h5500_0000 + 32'(i) * 32'h111;
    repeat (3) tick();
    check(busy == 0 && done == 0 && mem_req == 0 && rf_we == 0 && base_we == 0,
          "R1 reset outputs", {27'b0, busy, done, mem_req, rf_we, base_we}, 0);
    rst = 1'b0;
    tick();

    // upward post-index load of r1..r3 from 0x80010
    run(16'h000E, 32'h0008_0010, 1, 0, 1, 1, 0, nb, gb);
    check(gb == 32'h0008_001C, "R5 base after upward load", gb, 32'h0008_001C);
    check(nb == 5, "R2 busy cycles N=3", nb, 5);
    check(rf[1] == 32'hA000_0004, "R6 r1 loaded", rf[1], 32'hA000_0004);
    check(rf[3] == 32'hA000_0006, "R6 r3 loaded", rf[3], 32'hA000_0006);

    // downward pre-index store (stack push) of r2,r3 from 0x80014
    run(16'h000C, 32'h0008_0014, 0, 1, 0, 1, 0, nb, gb);
    check(gb == 32'h0008_000C, "R5 base after push", gb, 32'h0008_000C);
    check(mem[3] == rf[2], "R4 lowest register at lowest address", mem[3], rf[2]);
    check(mem[4] == rf[3], "R4 next register one word up", mem[4], rf[3]);

    // upward pre-index store with a stray start during the transfer
    run(16'hA5F0, 32'h0000_0100, 0, 1, 1, 0, 1, nb, gb);
    check(nb == 10, "R2 stray start ignored, N=8", nb, 10);
    check(mem[6'h01] == rf[4], "R4 pre-index upward first word", mem[6'h01], rf[4]);

    // downward post-index load without writeback, wait states
    rdy_mode = 1;
    run(16'h8001, 32'h0000_0040, 1, 0, 0, 0, 0, nb, gb);
    check(gb == 32'h0000_0038, "R5 downward base", gb, 32'h0000_0038);
    check(rf[0] == mem[6'h0F], "R8 r0 loaded under waits", rf[0], mem[6'h0F]);

    // empty selection
    rdy_mode = 0;
    run(16'h0000, 32'h0000_0200, 1, 1, 1, 1, 0, nb, gb);
    check(nb == 2, "R9 empty list busy cycles", nb, 2);
    check(gb == 32'h0000_0200, "R9 empty list base unchanged", gb, 32'h0000_0200);
    check(new_base == 32'h0000_0200, "R10 new_base held after done", new_base, 32'h0000_0200);

    // all sixteen registers, random waits
    rdy_mode = 1;
    run(16'hFFFF, 32'h0000_0080, 0, 0, 1, 1, 0, nb, gb);
    check(gb == 32'h0000_00C0, "R5 full list base", gb, 32'h0000_00C0);
    check(mem[6'h2F] == rf[15], "R3 r15 at top word", mem[6'h2F], rf[15]);

    repeat (3) tick();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == 100000) begin
      misses++;
      $display("FAIL watchdog expired actual=%0d expected=finish", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end
endmodule